// File: doc/BRIEF.md
# Interrupt-Gated Transfer Activation Controller

This block sits between a set of interrupt request lines and a data transfer engine. Software writes a bank of byte-wide enable registers, one bit per request source. A pending request activates the engine only when its enable bit is set. When several enabled requests are pending at once, the lowest source index wins. Only one activation is outstanding at a time. It stays asserted, with its source index held, until the engine returns a done strobe.

A 16-bit block counter, loaded by software, counts completed transfers down. A loaded zero stands for 65,536 transfers. When the counter runs out, the block pulses an end indication and clears the serviced source's enable bit. A disable-after-transfer mode input makes the block clear that enable bit after every single completed transfer instead. A software write that lands in the same cycle as a hardware clear of the same bit loses to the clear.

Top module: `xfer_gate_ctrl`

## Requirements
- R1: After a synchronous reset, every enable register reads 0x00, and `act_req` and `end_pulse` are low.
- R2: A write with `reg_we` high stores `reg_wdata` into enable register `reg_addr` (0 to 6). Bit j of register a enables source a*8+j. `reg_rdata` shows the register selected by `reg_addr` one clock later. For addresses 7 and above, writes are ignored and reads return 0x00.
- R3: A request whose enable bit is 0 never raises `act_req`.
- R4: When idle, `act_req` rises one clock after an edge that sees at least one enabled pending request. `act_src` then gives the lowest such index.
- R5: While `act_req` is high and `xfer_done` is low, `act_req` and `act_src` hold. The clock after `xfer_done`, `act_req` is low.
- R6: `cnt_we` loads `cnt_wdata` into the counter. Each `xfer_done` during an activation decrements it by one. A loaded 0x0000 acts as 65,536, so the next decrement gives 0xFFFF with no end pulse.
- R7: A `xfer_done` that takes the counter from 1 to 0 raises `end_pulse` for exactly one clock and clears the serviced source's enable bit, whatever the mode.
- R8: With `dis_after` = 1, every `xfer_done` clears the serviced source's enable bit.
- R9: With `dis_after` = 0 and the counter not run out, the serviced source's enable bit keeps its value.
- R10: If a software write and a hardware clear hit the same register in one clock, the cleared bit ends at 0 and the other written bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Enable register write strobe |
| reg_addr | input | 3 | Enable register select |
| reg_wdata | input | 8 | Enable register write data |
| reg_rdata | output | 8 | Registered read data of selected register |
| irq_req | input | 56 | Interrupt request lines, one per source |
| cnt_we | input | 1 | Block counter load strobe |
| cnt_wdata | input | 16 | Block counter load value (0 means 65,536) |
| cnt_q | output | 16 | Current block counter value |
| xfer_done | input | 1 | Transfer completion strobe from the engine |
| dis_after | input | 1 | Clear the enable bit after every transfer |
| act_req | output | 1 | Activation request to the transfer engine |
| act_src | output | 6 | Index of the source being serviced |
| end_pulse | output | 1 | One-clock pulse when the counter reaches zero |

## Verification
The hardest case to reach from the ports is a software write and a hardware clear landing on the same register in the same clock. To get there, the bench waits until an activation is outstanding. It then drives `xfer_done` and a register write on the same falling edge and reads the register back. Reaching the 65,536 wrap is the other hard case. Instead of 65,536 transfers, the bench loads 0x0000 and checks the next two decrement values. Lowest-index ordering is tested with pending sources in more than one register, with disabled requests mixed in.

// File: rtl/xg_pkg.sv
package xg_pkg;
  localparam int unsigned XG_NUM_REGS = 7;
  localparam int unsigned XG_REG_W    = 8;
  localparam int unsigned XG_CNT_W    = 16;
endpackage

// File: rtl/xg_pick.sv
module xg_pick #(
  parameter int unsigned N     = 56,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/xg_enable_bank.sv
module xg_enable_bank #(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned NSRC     = NUM_REGS * REG_W,
  parameter int unsigned IDX_W    = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              clr,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [NSRC-1:0]   en_flat
);
  localparam int unsigned BIT_W = $clog2(REG_W);
  localparam int unsigned SEL_W = IDX_W - BIT_W;

  logic [REG_W-1:0] bank [NUM_REGS];
  logic [SEL_W-1:0] clr_reg;
  logic [BIT_W-1:0] clr_bit;

  assign clr_reg = clr_idx[IDX_W-1:BIT_W];
  assign clr_bit = clr_idx[BIT_W-1:0];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [REG_W-1:0] nxt;
    always_comb begin
      nxt = bank[r];
      if (we && addr == ADDR_W'(r)) nxt = wdata;
      if (clr && clr_reg == SEL_W'(r)) nxt[clr_bit] = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst) bank[r] <= '0;
      else     bank[r] <= nxt;
    end
    assign en_flat[r*REG_W +: REG_W] = bank[r];
  end

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (addr == ADDR_W'(r)) rd_mux = bank[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> en_flat == '0);
  assert_hw_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> !en_flat[$past(clr_idx)]);
endmodule

// File: rtl/xg_block_counter.sv
module xg_block_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] q,
  output logic             hit,
  output logic             end_pulse
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign hit = dec && !load && (q == ONE);

  always_ff @(posedge clk) begin
    if (load)     q <= load_val;
    else if (dec) q <= q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) end_pulse <= 1'b0;
    else     end_pulse <= hit;
  end

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    dec && !load |=> q == $past(q) - ONE);
  assert_end_single_R7: assert property (@(posedge clk) disable iff (rst)
    end_pulse |=> !end_pulse);
  assert_end_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    end_pulse |-> q == '0);
endmodule

// File: rtl/xfer_gate_ctrl.sv
module xfer_gate_ctrl
  import xg_pkg::*;
#(
  parameter int unsigned NUM_REGS = XG_NUM_REGS,
  parameter int unsigned REG_W    = XG_REG_W,
  parameter int unsigned CNT_W    = XG_CNT_W,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS + 1),
  parameter int unsigned NSRC     = NUM_REGS * REG_W,
  parameter int unsigned IDX_W    = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_q,
  input  logic              xfer_done,
  input  logic              dis_after,
  output logic              act_req,
  output logic [IDX_W-1:0]  act_src,
  output logic              end_pulse
);
  logic [NSRC-1:0]  en_flat;
  logic             pend_any;
  logic [IDX_W-1:0] pend_idx;
  logic             dec;
  logic             hit;
  logic             clr;

  assign dec = act_req && xfer_done;
  assign clr = dec && (dis_after || hit);

  xg_enable_bank #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .NSRC(NSRC), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .clr(clr), .clr_idx(act_src), .en_flat(en_flat)
  );

  xg_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
    .vec(irq_req & en_flat), .any(pend_any), .idx(pend_idx)
  );

  xg_block_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_we), .load_val(cnt_wdata), .dec(dec),
    .q(cnt_q), .hit(hit), .end_pulse(end_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_req <= 1'b0;
      act_src <= '0;
    end else if (!act_req) begin
      if (pend_any) begin
        act_req <= 1'b1;
        act_src <= pend_idx;
      end
    end else if (xfer_done) begin
      act_req <= 1'b0;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    act_req && !xfer_done |=> act_req && $stable(act_src));
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    act_req && xfer_done |=> !act_req);
  assert_no_end_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !act_req |=> !end_pulse);
endmodule

// File: tb/sim_xfer_gate_ctrl.sv
module sim_xfer_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [55:0] irq_req = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [15:0] cnt_q;
  logic        xfer_done = 1'b0;
  logic        dis_after = 1'b0;
  logic        act_req;
  logic [5:0]  act_src;
  logic        end_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int exp_q[$];
  logic act_prev = 1'b0;

  always #4 clk = ~clk;

  xfer_gate_ctrl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
    .xfer_done(xfer_done), .dis_after(dis_after), .act_req(act_req),
    .act_src(act_src), .end_pulse(end_pulse)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: each new activation pops the expected source
  always @(negedge clk) begin
    if (!rst && act_req && !act_prev) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected grant", {26'd0, act_src}, 32'hFFFF);
      end else begin
        chk("R4 grant source", {26'd0, act_src}, exp_q.pop_front());
      end
    end
    act_prev = act_req;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    tick();
    chk(tag, {24'd0, reg_rdata}, {24'd0, e});
  endtask

  task automatic load(input logic [15:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    tick();
    cnt_we = 1'b0;
  endtask

  task automatic wait_act();
    for (int i = 0; i < 50 && !act_req; i++) tick();
    chk("R4 activation seen", {31'd0, act_req}, 32'd1);
  endtask

  task automatic done();
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
  endtask

  task automatic idle_check(string tag);
    logic seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (act_req) seen = 1'b1;
    end
    chk(tag, {31'd0, seen}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 act_req", {31'd0, act_req}, 32'd0);
    chk("R1 end_pulse", {31'd0, end_pulse}, 32'd0);
    for (int a = 0; a < 7; a++) rd(3'(a), 8'h00, "R1 enable reg zero");

    // R2 register access
    wr(3'd0, 8'hA5); rd(3'd0, 8'hA5, "R2 reg0 write");
    wr(3'd6, 8'h3C); rd(3'd6, 8'h3C, "R2 reg6 write");
    wr(3'd7, 8'hFF); rd(3'd7, 8'h00, "R2 addr7 reads zero");
    rd(3'd6, 8'h3C, "R2 addr7 write ignored");
    wr(3'd0, 8'h00); wr(3'd6, 8'h00);

    // R3 gating: request without enable
    irq_req[5] = 1'b1;
    idle_check("R3 disabled request blocked");

    // R4/R5/R6/R9/R7 with dis_after=0
    dis_after = 1'b0;
    load(16'd3);
    wr(3'd0, 8'h24);
    exp_q.push_back(2);
    irq_req = '0; irq_req[2] = 1'b1; irq_req[5] = 1'b1; irq_req[9] = 1'b1;
    wait_act();
    repeat (3) tick();
    chk("R5 hold req", {31'd0, act_req}, 32'd1);
    chk("R5 hold src", {26'd0, act_src}, 32'd2);
    exp_q.push_back(2);
    done();
    chk("R5 release", {31'd0, act_req}, 32'd0);
    chk("R6 count 3->2", {16'd0, cnt_q}, 32'd2);
    rd(3'd0, 8'h24, "R9 enable kept");
    wait_act();
    exp_q.push_back(5);
    done();
    chk("R6 count 2->1", {16'd0, cnt_q}, 32'd1);
    chk("R7 no early end", {31'd0, end_pulse}, 32'd0);
    irq_req[2] = 1'b0;
    wait_act();
    done();
    chk("R7 count zero", {16'd0, cnt_q}, 32'd0);
    chk("R7 end pulse high", {31'd0, end_pulse}, 32'd1);
    tick();
    chk("R7 end pulse one cycle", {31'd0, end_pulse}, 32'd0);
    rd(3'd0, 8'h04, "R7 enable cleared at end");
    idle_check("R3 cleared and disabled sources idle");

    // R6 wrap and R8 with dis_after=1
    dis_after = 1'b1;
    irq_req = '0;
    load(16'h0000);
    wr(3'd1, 8'h81);
    exp_q.push_back(8); exp_q.push_back(15);
    irq_req[8] = 1'b1; irq_req[15] = 1'b1;
    wait_act();
    done();
    chk("R6 zero load wraps", {16'd0, cnt_q}, 32'hFFFF);
    chk("R6 no end on wrap", {31'd0, end_pulse}, 32'd0);
    rd(3'd1, 8'h80, "R8 cleared after transfer");
    wait_act();
    done();
    chk("R6 count FFFE", {16'd0, cnt_q}, 32'hFFFE);
    rd(3'd1, 8'h00, "R8 second clear");
    idle_check("R8 no further grants");

    // R10 write and hardware clear in same cycle
    irq_req = '0;
    wr(3'd2, 8'h01);
    load(16'd5);
    exp_q.push_back(16);
    irq_req[16] = 1'b1;
    wait_act();
    xfer_done = 1'b1; reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h03;
    tick();
    xfer_done = 1'b0; reg_we = 1'b0;
    rd(3'd2, 8'h02, "R10 hardware clear wins");
    chk("R6 count 5->4", {16'd0, cnt_q}, 32'd4);
    irq_req = '0;
    repeat (3) tick();
    chk("R4 all expected grants seen", exp_q.size(), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule